// File: doc/BRIEF.md
# Multiprecision 16-bit ALU with Programmable Status Flag

This block is a registered 16-bit arithmetic and logic unit for signal processing datapaths. On each rising clock edge it captures two operands, an external carry input, a 5-bit opcode, a first-word marker and three fill bits. The captured instruction executes in the following cycle. Its result, carry-out and status flag are registered at the end of that cycle, so they appear at the ports one edge after the instruction executes.

Words wider than 16 bits can be built in two ways. Several units can be chained through the external carry, which is the cascade form. A single unit can also process the words of a wide number on successive cycles, taking its carry from a register that holds the previous cycle's carry-out, which is the multicycle form. A single status flag can be set to one of four detection modes. Two of them warn that a result is approaching the signed range limit, which helps with block floating point scaling. A third flags a true overflow. The fourth detects a zero across every word of a multiword result.

The operand multiplexers and register files sit outside this block. The least significant bits of the neighbouring registers, used by the divide-by-two opcodes, therefore enter as plain inputs.

Top module: `mpalu_core`

## Requirements
- R1: An instruction and its inputs are captured on rising edge N and execute during the cycle that follows. Result, carry_out and flag change on edge N+1.
- R2: Opcode 0x00 clears the operation. It yields result 0 and carry_out 0, stores 0 in the carry register and sets the flag mode to overflow detection.
- R3: The arithmetic opcodes are as follows. 0x01/0x02/0x03 compute ~A+c. 0x08/0x09 compute A+B+c. 0x0A/0x0B/0x0C compute A+~B+c. 0x0D/0x0E/0x0F compute ~A+B+c. Within each group of three the carry c is a constant 1, then carry_in, then the carry register, in that order. For A+B, 0x08 uses carry_in and 0x09 uses the carry register. carry_out is bit 16 of the sum.
- R4: At the end of every executed cycle the carry-out is stored in the carry register. A multicycle opcode in the next instruction uses that stored value, so two successive words form a 32-bit sum.
- R5: Opcodes 0x04 to 0x07 give A shifted right by one place with the LSB dropped. The new MSB is filled from a different source for each opcode. 0x04 copies A[15]. 0x05 uses alu_left_lsb. 0x06 uses alu_right_lsb. 0x07 uses shift_reg_lsb.
- R6: The logic opcodes are 0x10 A&B, 0x11 A&~B, 0x12 ~A&B, 0x13 A|B, 0x14 ~A|B, 0x15 A^B, 0x16 A and 0x17 ~A.
- R7: Opcodes 0x18, 0x19, 0x1A and 0x1B select the flag mode: overflow, within a factor of two, within a factor of four, and zero. They produce result 0. The new mode already applies to the flag of the selecting instruction.
- R8: Opcodes 0x1C, 0x1D, 0x1E and 0x1F produce 0x0001, 0x00FF, 0x000F and 0x5555.
- R9: In overflow mode the flag is the XOR of the carry into bit 15 and the carry out of bit 15. Opcodes that are not arithmetic give 0.
- R10: In factor-of-two mode the flag is result[15] XOR result[14]. In factor-of-four mode the flag is 1 when result[15], result[14] and result[13] are not all equal.
- R11: In zero mode the flag is 1 when the result is 0 and either first_word is 1 or every earlier word since the last first_word was also 0. A nonzero word keeps the flag low until the next first_word.
- R12: The shift, logic, constant, mode-select and clear opcodes give carry_out 0. The carry register still updates.
- R13: A synchronous active-low reset gives result 0, carry_out 0 and flag 0, selects overflow mode and captures opcode 0x00 in the input stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| carry_in | input | 1 | External carry for the cascade opcodes |
| opcode | input | 5 | Instruction code |
| first_word | input | 1 | Marks the least significant word of a multiword zero test |
| alu_left_lsb | input | 1 | Fill bit for opcode 0x05 |
| alu_right_lsb | input | 1 | Fill bit for opcode 0x06 |
| shift_reg_lsb | input | 1 | Fill bit for opcode 0x07 |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Registered carry-out, which is also the multicycle carry source |
| flag | output | 1 | Registered status flag |

## Verification
The hidden state is the carry register, the flag-mode register and the sticky zero bit. If any of them is wrong, the fault shows up only when a later instruction reads it. A bad carry register corrupts the result of the next multicycle opcode, one edge after that opcode executes. A bad mode or sticky bit shows as a wrong flag on the first result that the mode judges differently. The stimulus therefore mixes mode changes, multicycle chains and first_word patterns, so that every stored bit is read soon after it is written.

// File: rtl/mpalu_pkg.sv
// Package: shared types for the multiprecision ALU.
// Holds the operation classes, the carry source choices, the flag modes
// and the decoded control word. Nothing here depends on the data width.
package mpalu_pkg;

    typedef enum logic [2:0] {
        K_CLEAR   = 3'd0,
        K_ARITH   = 3'd1,
        K_HALF    = 3'd2,
        K_LOGIC   = 3'd3,
        K_FLAGSEL = 3'd4,
        K_CONST   = 3'd5
    } op_class_e;

    typedef enum logic [1:0] {
        CS_ZERO = 2'd0,
        CS_ONE  = 2'd1,
        CS_EXT  = 2'd2,
        CS_REG  = 2'd3
    } carry_sel_e;

    typedef enum logic [1:0] {
        FM_OVF  = 2'd0,
        FM_TWO  = 2'd1,
        FM_FOUR = 2'd2,
        FM_ZERO = 2'd3
    } flag_mode_e;

    typedef struct packed {
        op_class_e  cls;
        logic       inv_a;
        logic       inv_b;
        logic       use_b;
        carry_sel_e csel;
        logic [1:0] sub;   // fill source, constant index or flag mode
        logic [2:0] fn;    // logic function index
    } alu_ctl_t;

endpackage

// File: rtl/mpalu_decode.sv
// Module: opcode decoder.
// Maps the 5-bit opcode onto a control word. It is purely combinational
// and assumes the opcode has already been registered by the caller.
module mpalu_decode
    import mpalu_pkg::*;
(
    input  logic [4:0] op,
    output alu_ctl_t   ctl
);

    // Purpose: one control word for each opcode.
    always_comb begin
        ctl       = '0;
        ctl.cls   = K_CLEAR;
        ctl.csel  = CS_ZERO;
        ctl.sub   = op[1:0];
        ctl.fn    = op[2:0];
        unique case (op)
            5'h00: ctl.cls = K_CLEAR;
            5'h01, 5'h02, 5'h03: begin
                ctl.cls   = K_ARITH;
                ctl.inv_a = 1'b1;
                ctl.use_b = 1'b0;
                ctl.csel  = (op == 5'h01) ? CS_ONE :
                            (op == 5'h02) ? CS_EXT : CS_REG;
            end
            5'h04, 5'h05, 5'h06, 5'h07: ctl.cls = K_HALF;
            5'h08, 5'h09: begin
                ctl.cls   = K_ARITH;
                ctl.use_b = 1'b1;
                ctl.csel  = (op == 5'h08) ? CS_EXT : CS_REG;
            end
            5'h0A, 5'h0B, 5'h0C: begin
                ctl.cls   = K_ARITH;
                ctl.use_b = 1'b1;
                ctl.inv_b = 1'b1;
                ctl.csel  = (op == 5'h0A) ? CS_ONE :
                            (op == 5'h0B) ? CS_EXT : CS_REG;
            end
            5'h0D, 5'h0E, 5'h0F: begin
                ctl.cls   = K_ARITH;
                ctl.use_b = 1'b1;
                ctl.inv_a = 1'b1;
                ctl.csel  = (op == 5'h0D) ? CS_ONE :
                            (op == 5'h0E) ? CS_EXT : CS_REG;
            end
            5'h10, 5'h11, 5'h12, 5'h13,
            5'h14, 5'h15, 5'h16, 5'h17: ctl.cls = K_LOGIC;
            5'h18, 5'h19, 5'h1A, 5'h1B: ctl.cls = K_FLAGSEL;
            default:                     ctl.cls = K_CONST;
        endcase
    end

endmodule

// File: rtl/mpalu_exec.sv
// Module: combinational execution unit.
// Computes the result, the carry out of the MSB and the carry into the
// MSB for one decoded instruction. Assumes W >= 4. Only arithmetic
// operations report a nonzero carry.
module mpalu_exec
    import mpalu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_ctl_t       ctl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           ext_c,
    input  logic           reg_c,
    input  logic           fill_left,
    input  logic           fill_right,
    input  logic           fill_shift,
    output logic [W-1:0]   res,
    output logic           c_msb_out,
    output logic           c_msb_in
);

    localparam logic [W-1:0] K_ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] K_HALFMSK = {{(W-W/2){1'b0}}, {(W/2){1'b1}}};
    localparam logic [W-1:0] K_QUARTER = {{(W-W/4){1'b0}}, {(W/4){1'b1}}};

    logic [W-1:0] alt_pat;
    logic [W-1:0] a_eff, b_eff;
    logic         cin;
    logic [W-1:0] lo_sum;
    logic [1:0]   hi_sum;
    logic [W-1:0] sum;
    logic         fill_bit;
    logic [W-1:0] logic_res;
    logic [W-1:0] const_res;

    // Purpose: alternating 0101 pattern, generated for any width.
    for (genvar g = 0; g < W; g++) begin : g_alt
        assign alt_pat[g] = ((g % 2) == 0) ? 1'b1 : 1'b0;
    end

    // Purpose: select the operand polarity and the carry source.
    always_comb begin
        a_eff = ctl.inv_a ? ~a : a;
        b_eff = ctl.use_b ? (ctl.inv_b ? ~b : b) : '0;
        unique case (ctl.csel)
            CS_ONE:  cin = 1'b1;
            CS_EXT:  cin = ext_c;
            CS_REG:  cin = reg_c;
            default: cin = 1'b0;
        endcase
    end

    // Purpose: split adder exposing the carry into and out of the MSB.
    always_comb begin
        lo_sum = {1'b0, a_eff[W-2:0]} + {1'b0, b_eff[W-2:0]}
               + {{(W-1){1'b0}}, cin};
        hi_sum = {1'b0, a_eff[W-1]} + {1'b0, b_eff[W-1]}
               + {1'b0, lo_sum[W-1]};
        sum    = {hi_sum[0], lo_sum[W-2:0]};
    end

    // Purpose: MSB fill source for the divide-by-two group.
    always_comb begin
        unique case (ctl.sub)
            2'd0:    fill_bit = a[W-1];
            2'd1:    fill_bit = fill_left;
            2'd2:    fill_bit = fill_right;
            default: fill_bit = fill_shift;
        endcase
    end

    // Purpose: bitwise functions.
    always_comb begin
        unique case (ctl.fn)
            3'd0:    logic_res = a & b;
            3'd1:    logic_res = a & ~b;
            3'd2:    logic_res = ~a & b;
            3'd3:    logic_res = a | b;
            3'd4:    logic_res = ~a | b;
            3'd5:    logic_res = a ^ b;
            3'd6:    logic_res = a;
            default: logic_res = ~a;
        endcase
    end

    // Purpose: mask constants.
    always_comb begin
        unique case (ctl.sub)
            2'd0:    const_res = K_ONE;
            2'd1:    const_res = K_HALFMSK;
            2'd2:    const_res = K_QUARTER;
            default: const_res = alt_pat;
        endcase
    end

    // Purpose: result and carry select by operation class.
    always_comb begin
        res       = '0;
        c_msb_out = 1'b0;
        c_msb_in  = 1'b0;
        unique case (ctl.cls)
            K_ARITH: begin
                res       = sum;
                c_msb_out = hi_sum[1];
                c_msb_in  = lo_sum[W-1];
            end
            K_HALF:  res = {fill_bit, a[W-1:1]};
            K_LOGIC: res = logic_res;
            K_CONST: res = const_res;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mpalu_flag.sv
// Module: programmable status flag.
// Holds the flag mode and the sticky zero bit and registers the flag.
// Assumes its inputs come from the instruction executing this cycle.
// A mode-select opcode already applies its new mode to its own flag.
module mpalu_flag
    import mpalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_class_e    cls,
    input  logic [1:0]   sel,
    input  logic [W-1:0] res,
    input  logic         c_msb_out,
    input  logic         c_msb_in,
    input  logic         first_w,
    output logic         flag_q
);

    flag_mode_e mode_q, mode_eff;
    logic       sticky_q;
    logic       zero_now;
    logic       hit;

    // Purpose: mode in force for the executing instruction.
    always_comb begin
        if (cls == K_FLAGSEL)    mode_eff = flag_mode_e'(sel);
        else if (cls == K_CLEAR) mode_eff = FM_OVF;
        else                     mode_eff = mode_q;
    end

    // Purpose: evaluate the detector chosen by the mode.
    always_comb begin
        zero_now = (res == '0) && (first_w || sticky_q);
        unique case (mode_eff)
            FM_OVF:  hit = c_msb_in ^ c_msb_out;
            FM_TWO:  hit = res[W-1] ^ res[W-2];
            FM_FOUR: hit = !((res[W-1] == res[W-2]) && (res[W-2] == res[W-3]));
            default: hit = zero_now;
        endcase
    end

    // Purpose: mode, sticky zero and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= FM_OVF;
            sticky_q <= 1'b1;
            flag_q   <= 1'b0;
        end else begin
            mode_q   <= mode_eff;
            sticky_q <= zero_now;
            flag_q   <= hit;
        end
    end

    // R11: once a later word is nonzero, the sticky bit stays low.
    a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_w && !sticky_q) |=> !sticky_q)
        else $error("a_r11_sticky_holds");

    // R7: a mode-select opcode leaves its mode in the register.
    a_r7_mode_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == K_FLAGSEL) |=> (mode_q == flag_mode_e'($past(sel))))
        else $error("a_r7_mode_taken");

endmodule

// File: rtl/mpalu_core.sv
// Module: multiprecision ALU top.
// Captures the operands, the instruction and the side inputs on each edge
// and executes them during the next cycle. Result, carry and flag are
// registered at the end of that cycle. The carry register is carry_out
// itself. Reset is synchronous and active low.
module mpalu_core
    import mpalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic [4:0]   opcode,
    input  logic         first_word,
    input  logic         alu_left_lsb,
    input  logic         alu_right_lsb,
    input  logic         shift_reg_lsb,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         flag
);

    logic [W-1:0] a_q, b_q;
    logic [4:0]   op_q;
    logic         ci_q, fw_q, fl_q, fr_q, fs_q;
    alu_ctl_t     ctl;
    logic [W-1:0] ex_res;
    logic         ex_cout, ex_cin15;
    logic [W-1:0] result_q;
    logic         carry_q;

    // Purpose: input stage. Reset loads the clear opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= 5'h00;
            ci_q <= 1'b0;
            fw_q <= 1'b0;
            fl_q <= 1'b0;
            fr_q <= 1'b0;
            fs_q <= 1'b0;
        end else begin
            a_q  <= op_a;
            b_q  <= op_b;
            op_q <= opcode;
            ci_q <= carry_in;
            fw_q <= first_word;
            fl_q <= alu_left_lsb;
            fr_q <= alu_right_lsb;
            fs_q <= shift_reg_lsb;
        end
    end

    mpalu_decode i_decode (
        .op  (op_q),
        .ctl (ctl)
    );

    mpalu_exec #(.W(W)) i_exec (
        .ctl        (ctl),
        .a          (a_q),
        .b          (b_q),
        .ext_c      (ci_q),
        .reg_c      (carry_q),
        .fill_left  (fl_q),
        .fill_right (fr_q),
        .fill_shift (fs_q),
        .res        (ex_res),
        .c_msb_out  (ex_cout),
        .c_msb_in   (ex_cin15)
    );

    mpalu_flag #(.W(W)) i_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (ctl.cls),
        .sel       (ctl.sub),
        .res       (ex_res),
        .c_msb_out (ex_cout),
        .c_msb_in  (ex_cin15),
        .first_w   (fw_q),
        .flag_q    (flag)
    );

    // Purpose: result register and carry register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            carry_q  <= 1'b0;
        end else begin
            result_q <= ex_res;
            carry_q  <= ex_cout;
        end
    end

    assign result    = result_q;
    assign carry_out = carry_q;

    // R2: the clear opcode leaves zero result, zero carry, no flag.
    a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == 5'h00) |=> (result == '0 && !carry_out && !flag))
        else $error("a_r2_clear_zeroes");

    // R7: mode selection forces a zero result.
    a_r7_select_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q[4:2] == 3'b110) |=> (result == '0))
        else $error("a_r7_select_zero");

    // R8: byte mask constant.
    a_r8_byte_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == 5'h1D) |=> (result == {{(W-W/2){1'b0}}, {(W/2){1'b1}}}))
        else $error("a_r8_byte_mask");

    // R12: opcodes in the upper half never produce a carry.
    a_r12_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_q[4] |=> !carry_out)
        else $error("a_r12_no_carry");

    // R5: sign-fill halving keeps the sign of A.
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == 5'h04) |=> (result[W-1] == $past(a_q[W-1])))
        else $error("a_r5_sign_kept");

endmodule

// File: tb/test_mpalu_core.sv
module test_mpalu_core;

    localparam int NMAX = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0;
    logic [4:0]  opcode = 5'h00;
    logic        first_word = 1'b0;
    logic        alu_left_lsb = 1'b0, alu_right_lsb = 1'b0, shift_reg_lsb = 1'b0;
    logic [15:0] result;
    logic        carry_out, flag;

    int total = 0;
    int bad = 0;
    int k = 0;
    bit done = 1'b0;

    logic [17:0] exp_q [0:NMAX-1];
    string       tag_q [0:NMAX-1];

    // model state
    bit       m_carry = 1'b0;
    int       m_mode = 0;
    bit       m_sticky = 1'b1;

    always #5 clk = ~clk;

    mpalu_core i_mpalu_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_a          (op_a),
        .op_b          (op_b),
        .carry_in      (carry_in),
        .opcode        (opcode),
        .first_word    (first_word),
        .alu_left_lsb  (alu_left_lsb),
        .alu_right_lsb (alu_right_lsb),
        .shift_reg_lsb (shift_reg_lsb),
        .result        (result),
        .carry_out     (carry_out),
        .flag          (flag)
    );

    function automatic string tag_for(input logic [4:0] op);
        if (op == 5'h00)       return "R2";
        else if (op < 5'h04)   return "R3";
        else if (op < 5'h08)   return "R5";
        else if (op < 5'h10)   return "R3";
        else if (op < 5'h18)   return "R6";
        else if (op < 5'h1C)   return "R7";
        else                   return "R8";
    endfunction

    // Reference model of one executed instruction, written from the requirements.
    task automatic model(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                         input bit ci, input bit fw, input bit fl, input bit fr, input bit fs,
                         output logic [17:0] e);
        int x, y, c, s, lo;
        logic [15:0] r;
        bit co, c15, arith, zn, f;
        int mode_now;
        arith = 1'b0; co = 1'b0; c15 = 1'b0; r = 16'h0;
        x = 0; y = 0; c = 0;
        mode_now = m_mode;
        case (op)
            5'h01, 5'h02, 5'h03: begin x = 32'(~a); y = 0; arith = 1'b1; end
            5'h08, 5'h09:        begin x = a; y = b; arith = 1'b1; end
            5'h0A, 5'h0B, 5'h0C: begin x = a; y = 32'(~b); arith = 1'b1; end
            5'h0D, 5'h0E, 5'h0F: begin x = 32'(~a); y = b; arith = 1'b1; end
            default: ;
        endcase
        case (op)
            5'h01, 5'h0A, 5'h0D: c = 1;
            5'h02, 5'h08, 5'h0B, 5'h0E: c = ci;
            5'h03, 5'h09, 5'h0C, 5'h0F: c = m_carry;
            default: c = 0;
        endcase
        if (arith) begin
            x = x & 32'hFFFF; y = y & 32'hFFFF;
            s  = x + y + c;
            lo = (x & 32'h7FFF) + (y & 32'h7FFF) + c;
            r  = s[15:0];
            co = s[16];
            c15 = lo[15];
        end else if (op >= 5'h04 && op <= 5'h07) begin
            bit fb;
            fb = (op == 5'h04) ? a[15] : (op == 5'h05) ? fl : (op == 5'h06) ? fr : fs;
            r = {fb, a[15:1]};
        end else if (op >= 5'h10 && op <= 5'h17) begin
            case (op[2:0])
                3'd0: r = a & b;
                3'd1: r = a & ~b;
                3'd2: r = ~a & b;
                3'd3: r = a | b;
                3'd4: r = ~a | b;
                3'd5: r = a ^ b;
                3'd6: r = a;
                default: r = ~a;
            endcase
        end else if (op >= 5'h1C) begin
            case (op[1:0])
                2'd0: r = 16'h0001;
                2'd1: r = 16'h00FF;
                2'd2: r = 16'h000F;
                default: r = 16'h5555;
            endcase
        end
        if (op >= 5'h18 && op <= 5'h1B) mode_now = int'(op[1:0]);
        if (op == 5'h00) mode_now = 0;
        zn = (r == 16'h0) && (fw || m_sticky);
        case (mode_now)
            0: f = c15 ^ co;
            1: f = r[15] ^ r[14];
            2: f = !((r[15] == r[14]) && (r[14] == r[13]));
            default: f = zn;
        endcase
        m_mode = mode_now;
        m_sticky = zn;
        m_carry = co;
        e = {r, co, f};
    endtask

    // Check the instruction issued two cycles ago, then issue a new one.
    task automatic issue(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                         input bit ci, input bit fw, input bit fl, input bit fr, input bit fs,
                         input string tag);
        logic [17:0] e;
        @(negedge clk);
        if (k >= 2) begin
            e = exp_q[k-2];
            total++;
            if ({result, carry_out, flag} !== e) begin
                bad++;
                $display("FAIL %s step %0d: res=%h cout=%b flag=%b expected res=%h cout=%b flag=%b",
                         tag_q[k-2], k-2, result, carry_out, flag, e[17:2], e[1], e[0]);
            end
        end
        op_a = a; op_b = b; carry_in = ci; opcode = op; first_word = fw;
        alu_left_lsb = fl; alu_right_lsb = fr; shift_reg_lsb = fs;
        model(op, a, b, ci, fw, fl, fr, fs, e);
        exp_q[k] = e;
        tag_q[k] = tag;
        k++;
    endtask

    task automatic check_reset;
        @(negedge clk);
        total++;
        if (result !== 16'h0 || carry_out !== 1'b0 || flag !== 1'b0) begin
            bad++;
            $display("FAIL R13 reset: res=%h cout=%b flag=%b expected res=0000 cout=0 flag=0",
                     result, carry_out, flag);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog expired: got no end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1601));
        repeat (3) @(posedge clk);
        check_reset();   // R13
        check_reset();   // R13
        @(negedge clk);
        rst_n = 1'b1;

        // R1: latency checked on every step; first a plain pass
        issue(5'h16, 16'h1234, 16'h0, 0, 1, 0, 0, 0, "R1");
        // R2 clear
        issue(5'h00, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, "R2");
        // R9 overflow: 7FFF + 0001
        issue(5'h08, 16'h7FFF, 16'h0001, 0, 0, 0, 0, 0, "R9");
        // R3 subtract A + ~B + 1
        issue(5'h0A, 16'h0005, 16'h0003, 0, 0, 0, 0, 0, "R3");
        // R4 32-bit add in two cycles
        issue(5'h08, 16'hFFFF, 16'h0001, 0, 0, 0, 0, 0, "R4");
        issue(5'h09, 16'h0001, 16'h0002, 0, 0, 0, 0, 0, "R4");
        issue(5'h02, 16'h0000, 16'h0000, 1, 0, 0, 0, 0, "R3");
        issue(5'h0F, 16'h0003, 16'h0010, 0, 0, 0, 0, 0, "R4");
        // R5 halving fills
        issue(5'h04, 16'h8002, 16'h0, 0, 0, 0, 0, 0, "R5");
        issue(5'h05, 16'h0002, 16'h0, 0, 0, 1, 0, 0, "R5");
        issue(5'h06, 16'h0002, 16'h0, 0, 0, 0, 1, 0, "R5");
        issue(5'h07, 16'h0002, 16'h0, 0, 0, 1, 1, 0, "R5");
        // R12 carry drops after logic
        issue(5'h08, 16'h8000, 16'h8000, 0, 0, 0, 0, 0, "R12");
        issue(5'h12, 16'h0F0F, 16'hFFFF, 0, 0, 0, 0, 0, "R6");
        // R7 / R10 factor-of-two and four
        issue(5'h19, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, "R7");
        issue(5'h16, 16'h4000, 16'h0, 0, 0, 0, 0, 0, "R10");
        issue(5'h16, 16'hC000, 16'h0, 0, 0, 0, 0, 0, "R10");
        issue(5'h1A, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R7");
        issue(5'h16, 16'h2000, 16'h0, 0, 0, 0, 0, 0, "R10");
        issue(5'h16, 16'h1000, 16'h0, 0, 0, 0, 0, 0, "R10");
        // R8 constants
        issue(5'h1C, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R8");
        issue(5'h1D, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R8");
        issue(5'h1E, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R8");
        issue(5'h1F, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R8");
        // R11 multiword zero
        issue(5'h1B, 16'h0, 16'h0, 0, 1, 0, 0, 0, "R11");
        issue(5'h16, 16'h0000, 16'h0, 0, 1, 0, 0, 0, "R11");
        issue(5'h16, 16'h0005, 16'h0, 0, 0, 0, 0, 0, "R11");
        issue(5'h16, 16'h0000, 16'h0, 0, 0, 0, 0, 0, "R11");
        issue(5'h16, 16'h0000, 16'h0, 0, 1, 0, 0, 0, "R11");
        issue(5'h16, 16'h0000, 16'h0, 0, 0, 0, 0, 0, "R11");
        issue(5'h18, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R7");

        // constrained random mix
        for (int i = 0; i < 900; i++) begin
            logic [4:0]  rop;
            logic [15:0] ra, rb;
            rop = 5'($urandom_range(0, 31));
            if (rop == 5'h00 && ($urandom_range(0, 3) != 0)) rop = 5'h09;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if ($urandom_range(0, 5) == 0) ra = 16'h0;
            if ($urandom_range(0, 5) == 0) rb = ra;
            issue(rop, ra, rb, 1'($urandom), ($urandom_range(0, 2) == 0),
                  1'($urandom), 1'($urandom), 1'($urandom), tag_for(rop));
        end
        issue(5'h16, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R1");
        issue(5'h16, 16'h0, 16'h0, 0, 0, 0, 0, 0, "R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule